// File: doc/BRIEF.md
# Port-Group Forwarding Mask Resolver

This block sits in the analyzer of a small Ethernet switch and decides where each frame goes. It keeps a writable table of port-group masks, each 13 bits wide: twelve front-panel ports plus one position for the CPU, whose bit number is set by a configuration input. For every frame it takes the MAC-table lookup result, the ingress port, a frame class and a hash. It reads three masks from the table: a destination group, an aggregation group and a source group. It then returns the egress mask for the front-panel ports, a CPU-copy flag and a CPU queue number.

A frame that hits in the MAC table uses the group named by the entry. A frame that misses is flooded through one of two flood groups, picked by frame class. A normal forwarding decision is the AND of the three masks. The CPU is handled differently. A MAC-table hit of entry type 0 or 1 whose destination group holds the CPU bit copies the frame to the CPU even when the aggregation and source masks exclude it. Flooded frames reach the CPU only if the CPU bit survives the full AND.

Lookup requests enter on a valid/ready stream, and results leave on another one. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. A result is consumed in a cycle where `res_valid` and `res_ready` are both high. While a result is waiting, the whole two-stage pipeline freezes, so `req_ready` is low exactly when a held result is not being taken. The table write port is a plain control interface that needs no handshake.

Top module: `pgm_resolver`

## Requirements
- R1: The front-panel output mask is the bitwise AND of the destination, aggregation and source masks, with the CPU bit position always cleared.
- R2: On a hit (`req_hit`=1) the destination mask is table entry `req_dest_idx`. An index of 96 or above reads as an all-zero mask with queue 0.
- R3: On a miss, class 0 (unicast) reads destination entry 60. Classes 1 (multicast), 2 (broadcast) and 3 read entry 61.
- R4: The aggregation mask is entry 64 + `req_hash`. The source mask is entry 80 + `req_src_port`.
- R5: On a hit with entry type 0 or 1 whose destination mask holds the CPU bit, `res_cpu_copy` is 1 whatever the aggregation and source masks hold.
- R6: In every other case, `res_cpu_copy` is 1 only when the CPU bit is set in the three-way AND.
- R7: `res_cpu_queue` is the 3-bit queue field of the destination entry when `res_cpu_copy` is 1, and 0 otherwise.
- R8: With `res_ready` held high, the result of a request accepted at clock edge N is presented with `res_valid` after edge N+2. Results come out in acceptance order, one per request.
- R9: While `res_valid`=1 and `res_ready`=0, all result outputs hold stable and `req_ready` is 0. Otherwise `req_ready` is 1.
- R10: After reset `res_valid` is 0, entries 64 to 79 hold an all-ones mask, and every other entry holds mask 0 and queue 0.
- R11: A write in the same cycle as an accepted lookup is not seen by that lookup. It is seen by every lookup accepted later.
- R12: The CPU port is sampled when a request is accepted. A value of 13 or above means there is no CPU bit: no copy is made and no mask bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_port | input | 4 | Bit position of the CPU in every mask |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 7 | Table entry to write |
| wr_mask | input | 13 | Port mask written to the entry |
| wr_queue | input | 3 | CPU queue field written to the entry |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_hit | input | 1 | MAC-table lookup hit |
| req_dest_idx | input | 7 | Group index from the matching MAC entry |
| req_etype | input | 2 | Entry type of the matching MAC entry |
| req_src_port | input | 4 | Ingress port number |
| req_class | input | 2 | Frame class: 0 unicast, 1 multicast, 2 broadcast |
| req_hash | input | 4 | Frame hash selecting the aggregation entry |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed when high |
| res_mask | output | 13 | Front-panel egress mask, CPU bit cleared |
| res_cpu_copy | output | 1 | Frame is copied to the CPU |
| res_cpu_queue | output | 3 | CPU extraction queue for the copy |

## Verification
A corrupted table entry or a wrong index shows up in `res_mask` two cycles after the first lookup that uses that entry. A wrong reset value of an aggregation entry shows up as missing ports on the first lookup that uses its hash. A broken CPU exception flips `res_cpu_copy` only for hits of type 0 or 1 whose source mask excludes the CPU, so directed cases target exactly that combination. A pipeline stage that fails to freeze under back-pressure either changes a held result on the very next cycle or drops or duplicates one, which the in-order comparison catches at the next handshake.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  // Frame class carried with each lookup request
  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_OTHER = 2'd3
  } fclass_e;

  // Entry types that allow the CPU copy to bypass aggregation and source masks
  function automatic logic etype_bypass(input logic [1:0] etype);
    return (etype == 2'd0) || (etype == 2'd1);
  endfunction

endpackage

// File: rtl/pgm_table.sv
module pgm_table #(
  parameter int DEPTH     = 96,
  parameter int MASK_W    = 13,
  parameter int Q_W       = 3,
  parameter int NRD       = 3,
  parameter int AGGR_BASE = 64,
  parameter int AGGR_CNT  = 16,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_addr,
  input  logic [MASK_W-1:0]                wr_mask,
  input  logic [Q_W-1:0]                   wr_q,
  input  logic                             rd_en,
  input  logic [NRD-1:0][IDX_W-1:0]        rd_addr,
  output logic [NRD-1:0][MASK_W-1:0]       rd_mask,
  output logic [Q_W-1:0]                   rd_q
);

  logic [MASK_W-1:0] mask_mem [DEPTH];
  logic [Q_W-1:0]    q_mem    [DEPTH];

  function automatic logic in_range(input logic [IDX_W-1:0] a);
    return {1'b0, a} < (IDX_W+1)'(DEPTH);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        mask_mem[e] <= (e >= AGGR_BASE && e < AGGR_BASE + AGGR_CNT) ? '1 : '0;
        q_mem[e]    <= '0;
      end
    end else if (wr_en && in_range(wr_addr)) begin
      mask_mem[wr_addr] <= wr_mask;
      q_mem[wr_addr]    <= wr_q;
    end
  end

  // Synchronous read ports; read before write on the same edge
  for (genvar k = 0; k < NRD; k++) begin : g_rd
    logic [MASK_W-1:0] mask_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_r <= '0;
      else if (rd_en) mask_r <= in_range(rd_addr[k]) ? mask_mem[rd_addr[k]] : '0;
    end
    assign rd_mask[k] = mask_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= in_range(rd_addr[0]) ? q_mem[rd_addr[0]] : '0;
  end

  // R11: a write is visible in the table one edge later
  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_range(wr_addr)) |=>
      (mask_mem[$past(wr_addr)] == $past(wr_mask)) && (q_mem[$past(wr_addr)] == $past(wr_q)));

  // R11: a read taken on a write edge returns the contents before that write
  p_read_old_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && in_range(rd_addr[0]) && (rd_addr[0] == wr_addr)) |=>
      (rd_mask[0] == $past(mask_mem[wr_addr])));

endmodule

// File: rtl/pgm_index.sv
module pgm_index
  import pgm_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int PORT_W    = 4,
  parameter int HASH_W    = 4,
  parameter int FLOOD_UC  = 60,
  parameter int FLOOD_MC  = 61,
  parameter int AGGR_BASE = 64,
  parameter int SRC_BASE  = 80
) (
  input  logic              hit,
  input  logic [IDX_W-1:0]  dest_idx,
  input  logic [1:0]        fclass,
  input  logic [HASH_W-1:0] hash,
  input  logic [PORT_W-1:0] src_port,
  output logic [IDX_W-1:0]  dest_addr,
  output logic [IDX_W-1:0]  aggr_addr,
  output logic [IDX_W-1:0]  src_addr
);

  fclass_e cls;

  always_comb begin
    cls = fclass_e'(fclass);
    if (hit)                 dest_addr = dest_idx;
    else if (cls == CLS_UNI) dest_addr = IDX_W'(FLOOD_UC);
    else                     dest_addr = IDX_W'(FLOOD_MC);
    aggr_addr = IDX_W'(AGGR_BASE) + IDX_W'(hash);
    src_addr  = IDX_W'(SRC_BASE) + IDX_W'(src_port);
  end

endmodule

// File: rtl/pgm_combine.sv
module pgm_combine
  import pgm_pkg::*;
#(
  parameter int MASK_W = 13,
  parameter int Q_W    = 3,
  parameter int CPU_W  = 4
) (
  input  logic              hit,
  input  logic [1:0]        etype,
  input  logic [CPU_W-1:0]  cpu_port,
  input  logic [MASK_W-1:0] dest_mask,
  input  logic [MASK_W-1:0] aggr_mask,
  input  logic [MASK_W-1:0] src_mask,
  input  logic [Q_W-1:0]    dest_q,
  output logic [MASK_W-1:0] out_mask,
  output logic              cpu_copy,
  output logic [Q_W-1:0]    cpu_queue
);

  logic [MASK_W-1:0] cpu_bit;
  logic [MASK_W-1:0] and_mask;
  logic              bypass_copy;
  logic              flood_copy;

  always_comb begin
    cpu_bit = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (cpu_port == CPU_W'(i)) cpu_bit[i] = 1'b1;
    end
  end

  always_comb begin
    and_mask    = dest_mask & aggr_mask & src_mask;
    bypass_copy = hit && etype_bypass(etype) && |(dest_mask & cpu_bit);
    flood_copy  = |(and_mask & cpu_bit);
    cpu_copy    = bypass_copy || flood_copy;
    out_mask    = and_mask & ~cpu_bit;
    cpu_queue   = cpu_copy ? dest_q : '0;
  end

endmodule

// File: rtl/pgm_resolver.sv
module pgm_resolver
  import pgm_pkg::*;
#(
  parameter int NUM_PORTS = 12,
  parameter int DEPTH     = 96,
  parameter int Q_W       = 3,
  parameter int HASH_W    = 4,
  parameter int FLOOD_UC  = 60,
  parameter int FLOOD_MC  = 61,
  parameter int AGGR_BASE = 64,
  parameter int SRC_BASE  = 80,
  localparam int MASK_W   = NUM_PORTS + 1,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int CPU_W    = $clog2(MASK_W),
  localparam int AGGR_CNT = 1 << HASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_W-1:0]  cpu_port,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [Q_W-1:0]    wr_queue,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_hit,
  input  logic [IDX_W-1:0]  req_dest_idx,
  input  logic [1:0]        req_etype,
  input  logic [PORT_W-1:0] req_src_port,
  input  logic [1:0]        req_class,
  input  logic [HASH_W-1:0] req_hash,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [MASK_W-1:0] res_mask,
  output logic              res_cpu_copy,
  output logic [Q_W-1:0]    res_cpu_queue
);

  localparam int NRD = 3;

  logic                        advance;
  logic [NRD-1:0][IDX_W-1:0]   rd_addr;
  logic [NRD-1:0][MASK_W-1:0]  rd_mask;
  logic [Q_W-1:0]              rd_q;

  logic                        s1_valid;
  logic                        s1_hit;
  logic [1:0]                  s1_etype;
  logic [CPU_W-1:0]            s1_cpu;
  logic [CPU_W-1:0]            res_cpu;

  logic [MASK_W-1:0]           cmb_mask;
  logic                        cmb_copy;
  logic [Q_W-1:0]              cmb_queue;

  // Whole pipeline moves together; it freezes only on a held result
  assign advance   = !res_valid || res_ready;
  assign req_ready = advance;

  pgm_index #(
    .IDX_W(IDX_W), .PORT_W(PORT_W), .HASH_W(HASH_W),
    .FLOOD_UC(FLOOD_UC), .FLOOD_MC(FLOOD_MC),
    .AGGR_BASE(AGGR_BASE), .SRC_BASE(SRC_BASE)
  ) u_index (
    .hit(req_hit), .dest_idx(req_dest_idx), .fclass(req_class),
    .hash(req_hash), .src_port(req_src_port),
    .dest_addr(rd_addr[0]), .aggr_addr(rd_addr[1]), .src_addr(rd_addr[2])
  );

  pgm_table #(
    .DEPTH(DEPTH), .MASK_W(MASK_W), .Q_W(Q_W), .NRD(NRD),
    .AGGR_BASE(AGGR_BASE), .AGGR_CNT(AGGR_CNT)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_q(wr_queue),
    .rd_en(advance), .rd_addr(rd_addr), .rd_mask(rd_mask), .rd_q(rd_q)
  );

  // Stage 1: request attributes travel alongside the table read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_etype <= '0;
      s1_cpu   <= '0;
    end else if (advance) begin
      s1_valid <= req_valid;
      s1_hit   <= req_hit;
      s1_etype <= req_etype;
      s1_cpu   <= cpu_port;
    end
  end

  pgm_combine #(.MASK_W(MASK_W), .Q_W(Q_W), .CPU_W(CPU_W)) u_combine (
    .hit(s1_hit), .etype(s1_etype), .cpu_port(s1_cpu),
    .dest_mask(rd_mask[0]), .aggr_mask(rd_mask[1]), .src_mask(rd_mask[2]),
    .dest_q(rd_q),
    .out_mask(cmb_mask), .cpu_copy(cmb_copy), .cpu_queue(cmb_queue)
  );

  // Stage 2: result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_mask      <= '0;
      res_cpu_copy  <= 1'b0;
      res_cpu_queue <= '0;
      res_cpu       <= '0;
    end else if (advance) begin
      res_valid     <= s1_valid;
      res_mask      <= cmb_mask;
      res_cpu_copy  <= cmb_copy;
      res_cpu_queue <= cmb_queue;
      res_cpu       <= s1_cpu;
    end
  end

  // R8: an accepted request reaches stage 1, then the output, on consecutive edges
  p_accept_s1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> s1_valid);
  p_s1_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && advance) |=> res_valid);

  // R9: a held result stays put, and stage 1 keeps its request
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_mask) && $stable(res_cpu_copy) &&
       $stable(res_cpu_queue) && $stable(s1_valid)));

  // R1: the CPU position never appears in the front-panel mask
  p_cpu_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_cpu < CPU_W'(MASK_W))) |-> !res_mask[res_cpu]);

  // R5: a qualifying hit with the CPU in its destination group is copied
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && s1_valid && s1_hit && etype_bypass(s1_etype) &&
     (s1_cpu < CPU_W'(MASK_W)) && rd_mask[0][s1_cpu]) |=> res_cpu_copy);

  // R7: no copy means queue zero
  p_queue_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_cpu_copy) |-> (res_cpu_queue == '0));

  // R12: no CPU position, no copy
  p_no_cpu_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_cpu >= CPU_W'(MASK_W))) |-> !res_cpu_copy);

endmodule

// File: tb/test_pgm_resolver.sv
`timescale 1ns/1ps
module test_pgm_resolver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cpu_port = 4'd12;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [12:0] wr_mask = '0;
  logic [2:0]  wr_queue = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_hit = 1'b0;
  logic [6:0]  req_dest_idx = '0;
  logic [1:0]  req_etype = '0;
  logic [3:0]  req_src_port = '0;
  logic [1:0]  req_class = '0;
  logic [3:0]  req_hash = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [12:0] res_mask;
  logic        res_cpu_copy;
  logic [2:0]  res_cpu_queue;

  always #5 clk = ~clk;

  pgm_resolver i_pgm_resolver (
    .clk(clk), .rst_n(rst_n), .cpu_port(cpu_port),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_queue(wr_queue),
    .req_valid(req_valid), .req_ready(req_ready), .req_hit(req_hit),
    .req_dest_idx(req_dest_idx), .req_etype(req_etype), .req_src_port(req_src_port),
    .req_class(req_class), .req_hash(req_hash),
    .res_valid(res_valid), .res_ready(res_ready), .res_mask(res_mask),
    .res_cpu_copy(res_cpu_copy), .res_cpu_queue(res_cpu_queue)
  );

  typedef struct {
    logic [12:0] m;
    logic        c;
    logic [2:0]  q;
    int          cyc;
    bit          lat;
    string       tag;
  } exp_t;

  exp_t        fifo[$];
  logic [12:0] tm_mask [96];
  logic [2:0]  tm_q    [96];
  int          checks = 0;
  int          errors = 0;
  int          cycle  = 0;
  bit          lat_mode = 1'b0;
  string       cur_tag = "R1";
  bit          hold_pend = 1'b0;
  logic [12:0] hold_m;
  logic        hold_c;
  logic [2:0]  hold_q;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic hit, input logic [6:0] idx,
                                 input logic [1:0] et, input logic [3:0] sp,
                                 input logic [1:0] cls, input logic [3:0] hs,
                                 input logic [3:0] cpu);
    exp_t r;
    logic [12:0] d, a, s, cb, am;
    logic [2:0]  dq;
    int di;
    if (hit) di = int'(idx);
    else     di = (cls == 2'd0) ? 60 : 61;   // R3
    d  = (di < 96) ? tm_mask[di] : 13'h0;      // R2
    dq = (di < 96) ? tm_q[di] : 3'd0;
    a  = tm_mask[64 + int'(hs)];              // R4
    s  = tm_mask[80 + int'(sp)];
    cb = (cpu < 4'd13) ? (13'h1 << cpu) : 13'h0;  // R12
    am = d & a & s;                           // R1
    r.c = (hit && (et < 2'd2) && ((d & cb) != 0)) || ((am & cb) != 0);  // R5 R6
    r.m = am & ~cb;
    r.q = r.c ? dq : 3'd0;                    // R7
    r.cyc = cycle;
    r.lat = lat_mode;
    r.tag = cur_tag;
    return r;
  endfunction

  // Evaluate the state before the coming edge, then step to the next negedge
  task automatic tick();
    #4;
    chk(req_ready == (!res_valid || res_ready), "R9", "req_ready",
        int'(req_ready), int'(!res_valid || res_ready));
    if (hold_pend)
      chk(res_valid && res_mask == hold_m && res_cpu_copy == hold_c &&
          res_cpu_queue == hold_q, "R9", "held result",
          int'(res_mask), int'(hold_m));
    hold_pend = res_valid && !res_ready;
    hold_m = res_mask; hold_c = res_cpu_copy; hold_q = res_cpu_queue;
    if (res_valid && res_ready) begin
      if (fifo.size() == 0) begin
        chk(1'b0, "R8", "unexpected result", int'(res_mask), 0);
      end else begin
        exp_t e;
        e = fifo.pop_front();
        chk(res_mask == e.m, e.tag, "mask", int'(res_mask), int'(e.m));
        chk(res_cpu_copy == e.c, e.tag, "cpu_copy", int'(res_cpu_copy), int'(e.c));
        chk(res_cpu_queue == e.q, e.tag, "cpu_queue", int'(res_cpu_queue), int'(e.q));
        if (e.lat) chk(cycle - e.cyc == 2, "R8", "latency", cycle - e.cyc, 2);
      end
    end
    if (req_valid && req_ready)
      fifo.push_back(model(req_hit, req_dest_idx, req_etype, req_src_port,
                           req_class, req_hash, cpu_port));
    if (wr_en && wr_addr < 7'd96) begin     // R11: model updated after the lookup
      tm_mask[wr_addr] = wr_mask;
      tm_q[wr_addr] = wr_queue;
    end
    cycle++;
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [12:0] m, input logic [2:0] q);
    wr_en = 1'b1; wr_addr = 7'(addr); wr_mask = m; wr_queue = q;
    req_valid = 1'b0;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rq(input logic hit, input int idx, input logic [1:0] et,
                    input int sp, input logic [1:0] cls, input int hs, input string tag);
    cur_tag = tag;
    req_valid = 1'b1; req_hit = hit; req_dest_idx = 7'(idx); req_etype = et;
    req_src_port = 4'(sp); req_class = cls; req_hash = 4'(hs);
    tick();
    req_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int e = 0; e < 96; e++) begin   // R10 reset contents
      tm_mask[e] = (e >= 64 && e < 80) ? 13'h1FFF : 13'h0;
      tm_q[e] = 3'd0;
    end
    repeat (3) @(negedge clk);
    #4;
    chk(res_valid == 1'b0, "R10", "res_valid in reset", int'(res_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #4;
    chk(res_valid == 1'b0 && req_ready == 1'b1, "R10", "after reset",
        int'({res_valid, req_ready}), 1);
    @(negedge clk);

    lat_mode = 1'b1;
    res_ready = 1'b1;
    cpu_port = 4'd12;
    rq(1'b1, 70, 2'd2, 3, 2'd0, 3, "R10");      // untouched entries read zero
    wr(5,  13'h0020, 3'd1);
    wr(59, 13'h1000, 3'd5);
    wr(60, 13'h1FFF, 3'd4);
    wr(61, 13'h1FFF, 3'd2);
    wr(83, 13'h0FF7, 3'd0);
    wr(84, 13'h1FEF, 3'd0);
    wr(40, 13'h1003, 3'd6);
    rq(1'b1, 59, 2'd0, 3, 2'd0, 0, "R5");
    rq(1'b1, 59, 2'd1, 3, 2'd1, 1, "R5");
    rq(1'b1, 59, 2'd2, 3, 2'd0, 0, "R6");
    rq(1'b1, 40, 2'd1, 3, 2'd0, 2, "R1");
    rq(1'b0, 0,  2'd0, 3, 2'd0, 0, "R3");
    rq(1'b0, 0,  2'd0, 4, 2'd2, 0, "R7");
    rq(1'b0, 0,  2'd0, 4, 2'd1, 0, "R6");
    rq(1'b0, 0,  2'd0, 3, 2'd3, 0, "R3");
    rq(1'b1, 100, 2'd0, 4, 2'd0, 0, "R2");
    rq(1'b1, 5,  2'd0, 4, 2'd0, 0, "R2");
    rq(1'b1, 61, 2'd3, 3, 2'd0, 6, "R10");
    wr(71, 13'h0F0F, 3'd0);
    rq(1'b0, 0,  2'd0, 3, 2'd0, 7, "R4");
    rq(1'b0, 0,  2'd0, 4, 2'd2, 7, "R4");
    // R11: write and lookup of entry 5 in the same cycle
    cur_tag = "R11";
    wr_en = 1'b1; wr_addr = 7'd5; wr_mask = 13'h0040; wr_queue = 3'd3;
    req_valid = 1'b1; req_hit = 1'b1; req_dest_idx = 7'd5; req_etype = 2'd0;
    req_src_port = 4'd4; req_class = 2'd0; req_hash = 4'd0;
    tick();
    wr_en = 1'b0;
    rq(1'b1, 5, 2'd0, 4, 2'd0, 0, "R11");
    // R12: no CPU position
    cpu_port = 4'd13;
    rq(1'b1, 59, 2'd0, 4, 2'd0, 0, "R12");
    rq(1'b0, 0,  2'd0, 4, 2'd2, 0, "R12");
    cpu_port = 4'd0;
    rq(1'b1, 40, 2'd0, 3, 2'd0, 0, "R12");
    cpu_port = 4'd12;
    repeat (3) tick();

    // Random phase with back-pressure
    lat_mode = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      int pick;
      cur_tag = "R1";
      res_ready = ($urandom % 4) != 0;
      wr_en = ($urandom % 5) == 0;
      pick = $urandom % 4;
      wr_addr = (pick == 0) ? 7'(59 + $urandom % 3) :
                (pick == 1) ? 7'(80 + $urandom % 16) : 7'($urandom % 96);
      wr_mask = 13'($urandom);
      wr_queue = 3'($urandom);
      req_valid = ($urandom % 3) != 0;
      req_hit = $urandom % 2;
      pick = $urandom % 3;
      req_dest_idx = (pick == 0) ? 7'(59 + $urandom % 3) : 7'($urandom % 128);
      req_etype = 2'($urandom);
      req_src_port = 4'($urandom);
      req_class = 2'($urandom);
      req_hash = 4'($urandom);
      if (($urandom % 50) == 0) cpu_port = 4'($urandom % 14);
      tick();
    end
    req_valid = 1'b0; wr_en = 1'b0; res_ready = 1'b1;
    for (int n = 0; n < 10; n++) tick();
    chk(fifo.size() == 0, "R8", "results outstanding", fifo.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule